// File: doc/BRIEF.md
# Transmit Underflow Recovery Controller

This block keeps the transmit descriptor pointer for a ring of buffer descriptors. It also decides what the transmit side does when the FIFO runs dry partway through a frame. A single configuration bit, `recov_en`, picks one of two policies:

- **Halt policy** (`recov_en` = 0): the underflow switches the transmitter off and raises a status flag.
- **Resynchronise policy** (`recov_en` = 1): the transmitter stays on, the frame in flight is dropped, and the controller walks the ring to the next descriptor that begins a frame.

During the walk, the controller hands every descriptor it skips back to the host. It wraps from the last ring entry to entry 0. If it meets a descriptor the host still holds, it waits in place until that descriptor is granted. When it lands on a start-of-frame descriptor, it emits a one-cycle launch strobe that carries that descriptor's index.

The descriptor read port is combinational. The block presents `desc_idx`, and the ring storage answers in the same cycle with the ownership and start-of-frame bits of that entry. Outside a recovery, the transmit engine moves the pointer with `desc_done`.

Top module: `txur_ctrl`

## Requirements
- R1: After `rst` the following all read 0: `tx_on`, `uflo_flag`, `cfg_rd`, `scan_busy`, `tx_start` and `desc_idx`.
- R2: A write on `cfg_we` shows `cfg_wdata` on `cfg_rd` from the next cycle. This holds at any time, including during a recovery walk.
- R3: `soft_rst` clears the configuration bit, `tx_on` and the pointer. `stop_cmd` leaves the configuration bit unchanged.
- R4: With the bit at 0, an underflow while `tx_on` is 1 clears `tx_on` on the next cycle. It produces no launch strobe and no descriptor release, and `desc_idx` does not move.
- R5: An underflow accepted while `tx_on` is 1 sets `uflo_flag` under either policy. The flag stays set until `uflo_clr`.
- R6: With the bit at 1, `tx_on` stays 1. The current descriptor is released unconditionally, one cycle after the underflow. Each following owned descriptor whose start-of-frame bit is 0 is then released, one per cycle, through `desc_release`.
- R7: The walk ends at the first owned descriptor with its start-of-frame bit set, counting from the one after the abandoned descriptor. At that point `tx_start` pulses for exactly one cycle, `tx_start_idx` gives that index, and `desc_idx` stays on it.
- R8: During the walk the index goes from RING_DEPTH-1 to 0.
- R9: A descriptor with `desc_own` = 0 pauses the walk. While paused, `desc_idx` holds and nothing is released or launched. The walk resumes once `desc_own` reads 1.
- R10: An underflow while `tx_on` is 0 is ignored: the flag stays 0 and no walk starts.
- R11: While no walk is in progress, each `desc_done` pulse moves `desc_idx` forward by one, wrapping from RING_DEPTH-1 to 0.
- R12: `stop_cmd` clears `tx_on` and ends a walk in progress. `start_cmd` sets `tx_on`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous hard reset, active high |
| soft_rst | input | 1 | Synchronous soft reset, active high |
| stop_cmd | input | 1 | Stop command: transmitter off, walk ended |
| start_cmd | input | 1 | Transmitter on |
| cfg_we | input | 1 | Write strobe for the policy bit |
| cfg_wdata | input | 1 | Policy bit value (1 = resynchronise) |
| cfg_rd | output | 1 | Current policy bit |
| desc_done | input | 1 | Transmit engine finished the current descriptor |
| uflo_evt | input | 1 | FIFO underflow event |
| uflo_clr | input | 1 | Clears the underflow flag |
| desc_idx | output | IDX_W | Index of the descriptor being looked at |
| desc_own | input | 1 | Controller owns entry `desc_idx` |
| desc_sof | input | 1 | Entry `desc_idx` starts a frame |
| desc_release | output | 1 | Return entry `desc_idx` to the host this cycle |
| tx_on | output | 1 | Transmitter running |
| uflo_flag | output | 1 | Underflow occurred |
| tx_start | output | 1 | One-cycle launch strobe |
| tx_start_idx | output | IDX_W | Index carried by the launch strobe |
| scan_busy | output | 1 | Recovery walk in progress |

## Verification
The bench targets several corner cases:

- **Abandoned descriptor is itself a frame start.** A design that launches on the current descriptor would replay the broken frame at once.
- **Walk across the end of the ring.** A design that fails to wrap would look at an entry outside the ring, or would stop early.
- **Host-held descriptor mid-walk.** Releasing it would steal a buffer the host owns. Skipping it would launch from the wrong frame.
- **Halt policy.** The bench checks that no release or launch appears, and that the flag sets under both policies.
- **Stop during a paused walk.** The bench confirms the walk is abandoned rather than resumed later.

// File: rtl/txur_pkg.sv
package txur_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ABANDON = 2'd1,
        ST_SCAN    = 2'd2
    } scan_st_t;

    typedef enum logic [1:0] {
        ACT_WAIT   = 2'd0,
        ACT_DROP   = 2'd1,
        ACT_LAUNCH = 2'd2
    } scan_act_t;

    typedef struct packed {
        logic own;
        logic sof;
    } desc_view_t;

    // What the walk does with the entry it is looking at
    function automatic scan_act_t classify(desc_view_t d);
        if (!d.own)
            return ACT_WAIT;
        else if (d.sof)
            return ACT_LAUNCH;
        else
            return ACT_DROP;
    endfunction

endpackage

// File: rtl/txur_cfg.sv
module txur_cfg (
    input  logic clk,
    input  logic rst,
    input  logic soft_rst,
    input  logic we,
    input  logic wdata,
    output logic q
);
    // Policy bit: hard and soft reset clear it, nothing else touches it
    always_ff @(posedge clk) begin
        if (rst || soft_rst)
            q <= 1'b0;
        else if (we)
            q <= wdata;
    end
endmodule

// File: rtl/txur_ring_ptr.sv
module txur_ring_ptr #(
    parameter int DEPTH = 8,
    localparam int W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         adv,
    output logic [W-1:0] idx
);
    logic [W-1:0] nxt;

    generate
        if ((1 << W) == DEPTH) begin : g_pow2
            // Natural binary wrap
            assign nxt = idx + 1'b1;
        end else begin : g_cmp
            assign nxt = (idx == W'(DEPTH - 1)) ? '0 : idx + 1'b1;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst || clr)
            idx <= '0;
        else if (adv)
            idx <= nxt;
    end
endmodule

// File: rtl/txur_fsm.sv
module txur_fsm
    import txur_pkg::*;
#(
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             soft_rst,
    input  logic             stop_cmd,
    input  logic             start_cmd,
    input  logic             uflo_evt,
    input  logic             uflo_clr,
    input  logic             recov_en,
    input  desc_view_t       desc,
    input  logic [IDX_W-1:0] cur_idx,
    output logic             release_o,
    output logic             tx_on,
    output logic             uflo_flag,
    output logic             tx_start,
    output logic [IDX_W-1:0] tx_start_idx,
    output logic             busy
);
    scan_st_t  st;
    scan_act_t act;

    always_comb begin
        act       = classify(desc);
        release_o = (st == ST_ABANDON) || ((st == ST_SCAN) && (act == ACT_DROP));
    end

    assign busy = (st != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst || soft_rst) begin
            st           <= ST_IDLE;
            tx_on        <= 1'b0;
            uflo_flag    <= 1'b0;
            tx_start     <= 1'b0;
            tx_start_idx <= '0;
        end else begin
            tx_start <= 1'b0;
            if (uflo_clr)
                uflo_flag <= 1'b0;
            if (stop_cmd) begin
                tx_on <= 1'b0;
                st    <= ST_IDLE;
            end else begin
                if (start_cmd)
                    tx_on <= 1'b1;
                unique case (st)
                    ST_IDLE: begin
                        if (uflo_evt && tx_on) begin
                            uflo_flag <= 1'b1;
                            if (recov_en)
                                st <= ST_ABANDON;
                            else
                                tx_on <= 1'b0;
                        end
                    end
                    ST_ABANDON: st <= ST_SCAN;
                    ST_SCAN: begin
                        if (act == ACT_LAUNCH) begin
                            tx_start     <= 1'b1;
                            tx_start_idx <= cur_idx;
                            st           <= ST_IDLE;
                        end
                    end
                    default: st <= ST_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/txur_ctrl.sv
module txur_ctrl
    import txur_pkg::*;
#(
    parameter int RING_DEPTH = 8,
    localparam int IDX_W = (RING_DEPTH > 1) ? $clog2(RING_DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             soft_rst,
    input  logic             stop_cmd,
    input  logic             start_cmd,
    input  logic             cfg_we,
    input  logic             cfg_wdata,
    output logic             cfg_rd,
    input  logic             desc_done,
    input  logic             uflo_evt,
    input  logic             uflo_clr,
    output logic [IDX_W-1:0] desc_idx,
    input  logic             desc_own,
    input  logic             desc_sof,
    output logic             desc_release,
    output logic             tx_on,
    output logic             uflo_flag,
    output logic             tx_start,
    output logic [IDX_W-1:0] tx_start_idx,
    output logic             scan_busy
);
    desc_view_t view;
    logic       ptr_adv;

    assign view.own = desc_own;
    assign view.sof = desc_sof;

    txur_cfg u_cfg (
        .clk      (clk),
        .rst      (rst),
        .soft_rst (soft_rst),
        .we       (cfg_we),
        .wdata    (cfg_wdata),
        .q        (cfg_rd)
    );

    // Walk steps take precedence; engine completions count only outside a walk
    assign ptr_adv = desc_release || (desc_done && !scan_busy);

    txur_ring_ptr #(.DEPTH(RING_DEPTH)) u_ptr (
        .clk (clk),
        .rst (rst),
        .clr (soft_rst),
        .adv (ptr_adv),
        .idx (desc_idx)
    );

    txur_fsm #(.IDX_W(IDX_W)) u_fsm (
        .clk          (clk),
        .rst          (rst),
        .soft_rst     (soft_rst),
        .stop_cmd     (stop_cmd),
        .start_cmd    (start_cmd),
        .uflo_evt     (uflo_evt),
        .uflo_clr     (uflo_clr),
        .recov_en     (cfg_rd),
        .desc         (view),
        .cur_idx      (desc_idx),
        .release_o    (desc_release),
        .tx_on        (tx_on),
        .uflo_flag    (uflo_flag),
        .tx_start     (tx_start),
        .tx_start_idx (tx_start_idx),
        .busy         (scan_busy)
    );
endmodule

// File: rtl/txur_chk.sv
module txur_chk #(
    parameter int RING_DEPTH = 8,
    localparam int IDX_W = (RING_DEPTH > 1) ? $clog2(RING_DEPTH) : 1
) (
    input logic             clk,
    input logic             rst,
    input logic             soft_rst,
    input logic             stop_cmd,
    input logic             cfg_we,
    input logic             cfg_wdata,
    input logic             cfg_rd,
    input logic             uflo_evt,
    input logic [IDX_W-1:0] desc_idx,
    input logic             desc_own,
    input logic             desc_release,
    input logic             tx_on,
    input logic             uflo_flag,
    input logic             tx_start,
    input logic             scan_busy
);
    assert_cfg_write_R2: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && !soft_rst) |=> (cfg_rd == $past(cfg_wdata)));

    assert_soft_clear_R3: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> (!cfg_rd && !tx_on));

    assert_halt_off_R4: assert property (@(posedge clk) disable iff (rst)
        (uflo_evt && tx_on && !scan_busy && !cfg_rd && !soft_rst) |=> !tx_on);

    assert_flag_set_R5: assert property (@(posedge clk) disable iff (rst)
        (uflo_evt && tx_on && !scan_busy && !soft_rst) |=> uflo_flag);

    assert_release_in_walk_R6: assert property (@(posedge clk) disable iff (rst)
        desc_release |-> scan_busy);

    assert_single_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        tx_start |=> !tx_start);

    assert_pause_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (scan_busy && !desc_own && !desc_release && !stop_cmd && !soft_rst)
            |=> $stable(desc_idx));

    assert_stop_off_R12: assert property (@(posedge clk) disable iff (rst)
        (stop_cmd && !soft_rst) |=> (!tx_on && !scan_busy));
endmodule

bind txur_ctrl txur_chk #(.RING_DEPTH(RING_DEPTH)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .soft_rst     (soft_rst),
    .stop_cmd     (stop_cmd),
    .cfg_we       (cfg_we),
    .cfg_wdata    (cfg_wdata),
    .cfg_rd       (cfg_rd),
    .uflo_evt     (uflo_evt),
    .desc_idx     (desc_idx),
    .desc_own     (desc_own),
    .desc_release (desc_release),
    .tx_on        (tx_on),
    .uflo_flag    (uflo_flag),
    .tx_start     (tx_start),
    .scan_busy    (scan_busy)
);

// File: tb/sim_txur_ctrl.sv
`timescale 1ns/1ps
module sim_txur_ctrl;
    localparam int DEPTH = 8;
    localparam int IW    = 3;
    localparam int NV    = 6;

    // Vector table: policy, start pointer, sof map, expected launch index,
    // expected release count, expected tx_on afterwards
    localparam int       V_MODE [NV] = '{1, 1, 1, 0, 1, 0};
    localparam int       V_PTR  [NV] = '{1, 6, 2, 2, 7, 5};
    localparam bit [7:0] V_SOF  [NV] = '{8'h11, 8'h41, 8'h0C, 8'h11, 8'h84, 8'hFF};
    localparam int       V_XIDX [NV] = '{4, 0, 3, 0, 2, 0};
    localparam int       V_XREL [NV] = '{3, 2, 1, 0, 3, 0};
    localparam int       V_XON  [NV] = '{1, 1, 1, 0, 1, 0};

    logic clk = 1'b0;
    logic rst = 1'b1, soft_rst = 1'b0, stop_cmd = 1'b0, start_cmd = 1'b0;
    logic cfg_we = 1'b0, cfg_wdata = 1'b0, desc_done = 1'b0;
    logic uflo_evt = 1'b0, uflo_clr = 1'b0;
    logic cfg_rd, desc_own, desc_sof, desc_release, tx_on, uflo_flag, tx_start, scan_busy;
    logic [IW-1:0] desc_idx, tx_start_idx;

    // Ring model: ownership lives in one process, requests come from the stimulus
    logic [7:0] own = 8'hFF;
    logic [7:0] sof = 8'h00;
    logic       load_req = 1'b0, grant_req = 1'b0, clr_req = 1'b0;
    logic [7:0] load_val = 8'hFF;
    logic [IW-1:0] grant_idx = '0;
    int rel_cnt = 0, start_cnt = 0, last_start = -1;

    int total = 0, bad = 0, cycles = 0;

    assign desc_own = own[desc_idx];
    assign desc_sof = sof[desc_idx];

    always #2 clk = ~clk;

    txur_ctrl #(.RING_DEPTH(DEPTH)) u0 (
        .clk(clk), .rst(rst), .soft_rst(soft_rst), .stop_cmd(stop_cmd),
        .start_cmd(start_cmd), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rd(cfg_rd), .desc_done(desc_done), .uflo_evt(uflo_evt),
        .uflo_clr(uflo_clr), .desc_idx(desc_idx), .desc_own(desc_own),
        .desc_sof(desc_sof), .desc_release(desc_release), .tx_on(tx_on),
        .uflo_flag(uflo_flag), .tx_start(tx_start), .tx_start_idx(tx_start_idx),
        .scan_busy(scan_busy)
    );

    always @(posedge clk) begin
        if (load_req) own <= load_val;
        else begin
            if (desc_release) own[desc_idx] <= 1'b0;
            if (grant_req) own[grant_idx] <= 1'b1;
        end
        if (clr_req) begin
            rel_cnt <= 0; start_cnt <= 0; last_start <= -1;
        end else begin
            if (desc_release) rel_cnt <= rel_cnt + 1;
            if (tx_start) begin
                start_cnt  <= start_cnt + 1;
                last_start <= int'(tx_start_idx);
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse(ref logic s);
        s = 1'b1; tick(1); s = 1'b0;
    endtask

    task automatic setup(input bit mode, input int ptr, input bit [7:0] smap, input bit [7:0] omap);
        rst = 1'b1; tick(2); rst = 1'b0;
        sof = smap; load_val = omap; load_req = 1'b1; clr_req = 1'b1;
        tick(1);
        load_req = 1'b0; clr_req = 1'b0;
        pulse(start_cmd);
        cfg_wdata = mode; pulse(cfg_we);
        for (int k = 0; k < ptr; k++) pulse(desc_done);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                total++; bad++;
                $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
                $display("  test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        tick(3);
        rst = 1'b0;
        tick(1);
        // R1 reset state
        chk(!tx_on && !uflo_flag && !cfg_rd && !scan_busy && !tx_start && desc_idx == 0,
            "R1", {tx_on, uflo_flag, cfg_rd, scan_busy, tx_start, desc_idx}, 0);

        // R10: underflow with transmitter off is ignored
        pulse(uflo_evt); tick(3);
        chk(!uflo_flag && !scan_busy, "R10", {uflo_flag, scan_busy}, 0);

        // Vector walk
        for (int v = 0; v < NV; v++) begin
            setup(V_MODE[v][0], V_PTR[v], V_SOF[v], 8'hFF);
            chk(int'(desc_idx) == V_PTR[v], "R11", int'(desc_idx), V_PTR[v]);
            clr_req = 1'b1; tick(1); clr_req = 1'b0;
            pulse(uflo_evt);
            tick(20);
            chk(int'(tx_on) == V_XON[v], V_MODE[v] != 0 ? "R6" : "R4", int'(tx_on), V_XON[v]);
            chk(uflo_flag, "R5", int'(uflo_flag), 1);
            chk(rel_cnt == V_XREL[v], V_MODE[v] != 0 ? "R6" : "R4", rel_cnt, V_XREL[v]);
            if (V_MODE[v] != 0) begin
                chk(start_cnt == 1, "R7", start_cnt, 1);
                chk(last_start == V_XIDX[v], (v == 1 || v == 4) ? "R8" : "R7", last_start, V_XIDX[v]);
                chk(int'(desc_idx) == V_XIDX[v], "R7", int'(desc_idx), V_XIDX[v]);
            end else begin
                chk(start_cnt == 0, "R4", start_cnt, 0);
                chk(int'(desc_idx) == V_PTR[v], "R4", int'(desc_idx), V_PTR[v]);
            end
        end

        // R5: flag stays until cleared
        tick(3);
        chk(uflo_flag, "R5", int'(uflo_flag), 1);
        pulse(uflo_clr); tick(1);
        chk(!uflo_flag, "R5", int'(uflo_flag), 0);

        // R2 / R3: config bit write, stop keeps it, soft reset clears it
        cfg_wdata = 1'b1; pulse(cfg_we);
        chk(cfg_rd, "R2", int'(cfg_rd), 1);
        pulse(stop_cmd);
        chk(cfg_rd && !tx_on, "R3", {cfg_rd, tx_on}, 2);
        pulse(start_cmd); pulse(desc_done);
        pulse(soft_rst);
        chk(!cfg_rd && !tx_on && desc_idx == 0, "R3", {cfg_rd, tx_on, desc_idx}, 0);

        // R11: pointer wraps on completions
        for (int k = 0; k < DEPTH + 1; k++) pulse(desc_done);
        chk(desc_idx == 1, "R11", int'(desc_idx), 1);

        // R9: host-held descriptor pauses the walk
        setup(1'b1, 1, 8'h10, 8'hF7);
        clr_req = 1'b1; tick(1); clr_req = 1'b0;
        pulse(uflo_evt);
        tick(10);
        chk(desc_idx == 3 && scan_busy, "R9", int'(desc_idx), 3);
        chk(rel_cnt == 2 && start_cnt == 0, "R9", rel_cnt * 10 + start_cnt, 20);
        // R2 during a walk
        cfg_wdata = 1'b1; pulse(cfg_we);
        chk(cfg_rd, "R2", int'(cfg_rd), 1);
        grant_idx = 3'd3; pulse(grant_req);
        tick(6);
        chk(start_cnt == 1 && last_start == 4, "R9", last_start, 4);
        chk(rel_cnt == 3 && tx_on, "R9", rel_cnt, 3);

        // R12: stop ends a paused walk, start turns transmitter on
        setup(1'b1, 1, 8'h10, 8'hF7);
        pulse(uflo_evt);
        tick(6);
        chk(scan_busy, "R12", int'(scan_busy), 1);
        pulse(stop_cmd);
        chk(!scan_busy && !tx_on, "R12", {scan_busy, tx_on}, 0);
        grant_idx = 3'd3; pulse(grant_req);
        tick(4);
        chk(start_cnt == 0 && desc_idx == 3, "R12", start_cnt, 0);
        pulse(start_cmd);
        chk(tx_on, "R12", int'(tx_on), 1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule